// File: doc/BRIEF.md
# Mitchell-Approximation Significand Multiplier

This block forms the product of two decoded small floating-point operands of the kind that sit in an 8-bit microscaled block. Examples are four-bit-exponent/three-bit-fraction or five-bit-exponent/two-bit-fraction elements. Each operand arrives already split into a sign, an unbiased signed exponent, a fraction of `FRAC_W` bits, and a zero flag. The block returns three things to the accumulator:

- a two's-complement fixed-point significand product with `2*FRAC_W` fraction bits;
- the summed exponent;
- a valid strobe.

A two-bit mode selects how the significands are combined:

- **Exact mode** multiplies the implied-one significands.
- **Log mode** replaces the multiplier with an adder and a conditional doubling. It uses the first-order logarithm rule log2(1+m) ≈ m for m in [0,1).
- **Hybrid mode** chooses per element. It computes exactly only when the caller marks the element as its block's largest ("block-max") element, and approximates all others.

The datapath is combinational. An optional output register (`REG_OUT`, default 1) gives one cycle of latency, with exactly one result for each valid input.

Top module: `mitchell_sig_mul`

## Requirements
- R1: With mode code 0, the magnitude of `p_val` equals (2^F+fa)·(2^F+fb), where F is `FRAC_W`, fa and fb are the fraction fields, and `p_val` carries 2F fraction bits.
- R2: With mode code 1 and fa+fb < 2^F, the magnitude of `p_val` equals (2^F+fa+fb)·2^F.
- R3: With mode code 1 and fa+fb ≥ 2^F, the magnitude of `p_val` equals 2·(fa+fb)·2^F, and it never exceeds the exact magnitude for the same operands.
- R4: With mode code 2, an element with `is_bm`=1 yields the R1 result and any other element yields the R2/R3 result.
- R5: For non-zero operands, `p_val` is negative (two's complement) exactly when `a_sign` XOR `b_sign` is 1.
- R6: For non-zero operands, `p_exp` equals the signed sum `a_exp`+`b_exp`.
- R7: If `a_zero` or `b_zero` is 1, both `p_val` and `p_exp` are 0 in every mode.
- R8: Mode code 3 behaves exactly as mode code 0.
- R9: With `REG_OUT`=1, `out_valid` is `in_valid` delayed by one cycle. Results load only on valid inputs, and `p_val`/`p_exp` hold their value across invalid cycles.
- R10: While `rst_n` is low, `out_valid`, `p_val` and `p_exp` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| mode | input | 2 | 0 exact, 1 log approximation, 2 hybrid, 3 same as 0 |
| is_bm | input | 1 | Element is the block-max element (used by hybrid mode) |
| a_sign | input | 1 | Sign of operand A |
| a_exp | input | EXP_W | Unbiased signed exponent of operand A |
| a_frac | input | FRAC_W | Fraction of operand A (implied leading one) |
| a_zero | input | 1 | Operand A is zero |
| b_sign | input | 1 | Sign of operand B |
| b_exp | input | EXP_W | Unbiased signed exponent of operand B |
| b_frac | input | FRAC_W | Fraction of operand B (implied leading one) |
| b_zero | input | 1 | Operand B is zero |
| out_valid | output | 1 | Product valid |
| p_val | output | 2*FRAC_W+3 | Signed significand product, 2*FRAC_W fraction bits |
| p_exp | output | EXP_W+1 | Signed product exponent |

## Verification
The assertions assume that `in_valid`, `mode` and the operand fields are free of X whenever `in_valid` is high. They also assume that a decoded non-zero operand always carries an implied leading one, so its significand lies in [1,2).

The stimulus keeps to this. It drives every field from defined values on the falling edge and never leaves a field undriven. It uses the zero flags to express zero operands instead of an all-zero fraction. Exponents are drawn across the full signed `EXP_W` range, so the sum exercises both extremes of `p_exp` without leaving its width.

// File: rtl/msm_pkg.sv
package msm_pkg;

  typedef enum logic [1:0] {
    MODE_EXACT  = 2'd0,
    MODE_LOG    = 2'd1,
    MODE_HYBRID = 2'd2,
    MODE_ALIAS  = 2'd3
  } mul_mode_e;

  // Decide per element whether the exact significand product is used.
  function automatic logic pick_exact(input logic [1:0] mode, input logic is_bm);
    case (mul_mode_e'(mode))
      MODE_LOG:    pick_exact = 1'b0;
      MODE_HYBRID: pick_exact = is_bm;
      default:     pick_exact = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/msm_exact_core.sv
module msm_exact_core #(
  parameter int FRAC_W = 3,
  localparam int SIG_W = 2 * FRAC_W + 2
) (
  input  logic [FRAC_W-1:0] fa,
  input  logic [FRAC_W-1:0] fb,
  output logic [SIG_W-1:0]  sig
);

  // (1.fa) * (1.fb) scaled by 2^(2F)
  function automatic logic [SIG_W-1:0] exact_sig(input logic [FRAC_W-1:0] x,
                                                 input logic [FRAC_W-1:0] y);
    logic [SIG_W-1:0] ox, oy;
    ox = SIG_W'({1'b1, x});
    oy = SIG_W'({1'b1, y});
    exact_sig = ox * oy;
  endfunction

  assign sig = exact_sig(fa, fb);

endmodule

// File: rtl/msm_log_core.sv
module msm_log_core #(
  parameter int FRAC_W = 3,
  localparam int SIG_W = 2 * FRAC_W + 2
) (
  input  logic [FRAC_W-1:0] fa,
  input  logic [FRAC_W-1:0] fb,
  output logic [SIG_W-1:0]  sig,
  output logic              carry
);

  // Fraction sum; its top bit marks ma+mb >= 1.
  function automatic logic [FRAC_W:0] frac_sum(input logic [FRAC_W-1:0] x,
                                               input logic [FRAC_W-1:0] y);
    frac_sum = {1'b0, x} + {1'b0, y};
  endfunction

  // Approximated significand product, rescaled to 2F fraction bits.
  function automatic logic [SIG_W-1:0] log_sig(input logic [FRAC_W:0] s);
    logic [SIG_W-1:0] ext;
    ext = SIG_W'(s);
    if (s[FRAC_W])
      log_sig = (ext << 1) << FRAC_W;
    else
      log_sig = ((SIG_W'(1) << FRAC_W) + ext) << FRAC_W;
  endfunction

  logic [FRAC_W:0] sum;

  assign sum   = frac_sum(fa, fb);
  assign carry = sum[FRAC_W];
  assign sig   = log_sig(sum);

endmodule

// File: rtl/msm_out_stage.sv
module msm_out_stage #(
  parameter int DW      = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          d_valid,
  input  logic [DW-1:0] d,
  output logic          q_valid,
  output logic [DW-1:0] q
);

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_valid <= 1'b0;
          q       <= '0;
        end else begin
          q_valid <= d_valid;
          if (d_valid) q <= d;
        end
      end
    end else begin : g_comb
      assign q_valid = d_valid;
      assign q       = d;
    end
  endgenerate

endmodule

// File: rtl/mitchell_sig_mul.sv
module mitchell_sig_mul #(
  parameter int FRAC_W  = 3,
  parameter int EXP_W   = 6,
  parameter bit REG_OUT = 1'b1,
  localparam int SIG_W  = 2 * FRAC_W + 2,
  localparam int VAL_W  = SIG_W + 1,
  localparam int PEXP_W = EXP_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [1:0]               mode,
  input  logic                     is_bm,
  input  logic                     a_sign,
  input  logic signed [EXP_W-1:0]  a_exp,
  input  logic [FRAC_W-1:0]        a_frac,
  input  logic                     a_zero,
  input  logic                     b_sign,
  input  logic signed [EXP_W-1:0]  b_exp,
  input  logic [FRAC_W-1:0]        b_frac,
  input  logic                     b_zero,
  output logic                     out_valid,
  output logic signed [VAL_W-1:0]  p_val,
  output logic signed [PEXP_W-1:0] p_exp
);

  import msm_pkg::*;

  localparam int DW = VAL_W + PEXP_W;

  // Named internal events, brought out for the checker.
  logic                     use_exact;
  logic                     any_zero;
  logic                     log_carry;
  logic [SIG_W-1:0]         ex_sig;
  logic [SIG_W-1:0]         lg_sig;
  logic [SIG_W-1:0]         sel_sig;
  logic                     c_neg;
  logic signed [VAL_W-1:0]  c_mag;
  logic signed [VAL_W-1:0]  c_val;
  logic signed [PEXP_W-1:0] c_exp;
  logic [DW-1:0]            stage_q;

  msm_exact_core #(.FRAC_W(FRAC_W)) u_exact (
    .fa  (a_frac),
    .fb  (b_frac),
    .sig (ex_sig)
  );

  msm_log_core #(.FRAC_W(FRAC_W)) u_log (
    .fa    (a_frac),
    .fb    (b_frac),
    .sig   (lg_sig),
    .carry (log_carry)
  );

  assign use_exact = pick_exact(mode, is_bm);
  assign any_zero  = a_zero | b_zero;
  assign sel_sig   = any_zero ? '0 : (use_exact ? ex_sig : lg_sig);
  assign c_neg     = (a_sign ^ b_sign) & ~any_zero;
  assign c_mag     = $signed({1'b0, sel_sig});
  assign c_val     = c_neg ? -c_mag : c_mag;
  assign c_exp     = any_zero ? '0 : (PEXP_W'(a_exp) + PEXP_W'(b_exp));

  msm_out_stage #(.DW(DW), .REG_OUT(REG_OUT)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_valid (in_valid),
    .d       ({c_val, c_exp}),
    .q_valid (out_valid),
    .q       (stage_q)
  );

  assign p_val = stage_q[DW-1:PEXP_W];
  assign p_exp = stage_q[PEXP_W-1:0];

endmodule

// File: rtl/msm_checker.sv
module msm_checker #(
  parameter int FRAC_W  = 3,
  parameter bit REG_OUT = 1'b1,
  localparam int SIG_W  = 2 * FRAC_W + 2,
  localparam int VAL_W  = SIG_W + 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [1:0]              mode,
  input logic                    is_bm,
  input logic                    a_sign,
  input logic                    b_sign,
  input logic                    a_zero,
  input logic                    b_zero,
  input logic                    use_exact,
  input logic [SIG_W-1:0]        ex_sig,
  input logic [SIG_W-1:0]        lg_sig,
  input logic signed [VAL_W-1:0] c_val,
  input logic                    out_valid,
  input logic signed [VAL_W-1:0] p_val
);

  localparam logic [SIG_W-1:0] UNITY = SIG_W'(1) << (2 * FRAC_W);

  // R1, R8: codes 0 and 3 select the exact path
  p_exact_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (mode == 2'd0 || mode == 2'd3) |-> use_exact);

  // R2: log mode never selects the exact path
  p_log_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode == 2'd1 |-> !use_exact);

  // R4: hybrid selects exact exactly for block-max elements
  p_hybrid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode == 2'd2 |-> use_exact == is_bm);

  // R3: the approximation stays in [1,4) and never exceeds the exact product
  p_under_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> lg_sig <= ex_sig && lg_sig >= UNITY);

  // R5: sign of the product follows the operand signs
  p_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !a_zero && !b_zero |-> c_val[VAL_W-1] == (a_sign ^ b_sign));

  generate
    if (REG_OUT) begin : g_seq
      // R9: one cycle latency
      p_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      p_novalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(p_val));
      // R7: zero operand gives a zero product
      p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (a_zero || b_zero) |=> p_val == '0);
    end
  endgenerate

endmodule

bind mitchell_sig_mul msm_checker #(.FRAC_W(FRAC_W), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/tb_mitchell_sig_mul.sv
module tb_mitchell_sig_mul;

  localparam int F  = 3;
  localparam int EW = 6;
  localparam int ONE = 1 << F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] mode = '0;
  logic is_bm = 1'b0;
  logic a_sign = 1'b0, b_sign = 1'b0, a_zero = 1'b0, b_zero = 1'b0;
  logic signed [EW-1:0] a_exp = '0, b_exp = '0;
  logic [F-1:0] a_frac = '0, b_frac = '0;
  logic out_valid;
  logic signed [2*F+2:0] p_val;
  logic signed [EW:0] p_exp;

  int n_checks = 0;
  int n_fails = 0;

  // reference state: results the outputs must show at the next falling edge
  int    m_val = 0, m_exp = 0;
  bit    m_valid = 0;
  int    pend_val = 0, pend_exp = 0;
  bit    pend_on = 0;
  string pend_tag = "R10";

  always #2.5 clk = ~clk;

  mitchell_sig_mul #(.FRAC_W(F), .EXP_W(EW), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .is_bm(is_bm),
    .a_sign(a_sign), .a_exp(a_exp), .a_frac(a_frac), .a_zero(a_zero),
    .b_sign(b_sign), .b_exp(b_exp), .b_frac(b_frac), .b_zero(b_zero),
    .out_valid(out_valid), .p_val(p_val), .p_exp(p_exp)
  );

  task automatic check(string tag, int act, int expv);
    n_checks++;
    if (act != expv) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Compare outputs, then drive one new vector.
  task automatic cycle(bit v, int md, bit bm, bit sa, int ea, int fa, bit za,
                       bit sb, int eb, int fb, bit zb);
    int mag, s;
    @(negedge clk);
    if (pend_on) begin m_val = pend_val; m_exp = pend_exp; end
    m_valid = pend_on;
    check("R9 valid", int'(out_valid), int'(m_valid));
    check({pend_tag, " value"}, int'(p_val), m_val);
    check(pend_on ? "R6 exponent" : "R9 hold exponent", int'(p_exp), m_exp);
    in_valid = v; mode = 2'(md); is_bm = bm;
    a_sign = sa; a_exp = EW'(ea); a_frac = F'(fa); a_zero = za;
    b_sign = sb; b_exp = EW'(eb); b_frac = F'(fb); b_zero = zb;
    pend_on = v;
    if (!v) begin
      pend_tag = "R9 hold";
    end else if (za || zb) begin
      pend_val = 0; pend_exp = 0; pend_tag = "R7";
    end else begin
      s = fa + fb;
      if (md == 1 || (md == 2 && !bm)) begin
        mag = (s < ONE) ? (ONE + s) * ONE : 2 * s * ONE;
        pend_tag = (md == 2) ? "R4" : ((s < ONE) ? "R2" : "R3");
      end else begin
        mag = (ONE + fa) * (ONE + fb);
        pend_tag = (md == 3) ? "R8" : ((md == 2) ? "R4" : "R1");
      end
      pend_val = (sa ^ sb) ? -mag : mag;
      if (sa ^ sb) pend_tag = {pend_tag, "/R5"};
      pend_exp = ea + eb;
    end
  endtask

  initial begin
    #2000000;
    n_fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #1;
    check("R10 valid", int'(out_valid), 0);
    check("R10 value", int'(p_val), 0);
    check("R10 exponent", int'(p_exp), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // exact mode
    cycle(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cycle(1, 0, 0, 0, 3, 7, 0, 1, -2, 7, 0);
    // log mode, no carry and carry
    cycle(1, 1, 0, 0, 1, 2, 0, 0, 1, 3, 0);
    cycle(1, 1, 0, 1, 5, 4, 0, 0, 5, 4, 0);
    cycle(1, 1, 0, 0, -1, 7, 0, 0, -1, 7, 0);
    // hybrid
    cycle(1, 2, 1, 0, 2, 5, 0, 0, 2, 6, 0);
    cycle(1, 2, 0, 0, 2, 5, 0, 0, 2, 6, 0);
    // alias code
    cycle(1, 3, 0, 1, 0, 3, 0, 1, 0, 5, 0);
    // zero operands in several modes
    cycle(1, 1, 0, 1, 9, 6, 1, 0, 4, 2, 0);
    cycle(1, 0, 0, 0, 9, 6, 0, 1, 4, 2, 1);
    // exponent extremes
    cycle(1, 0, 0, 0, -32, 1, 0, 0, -32, 1, 0);
    cycle(1, 0, 0, 0, 31, 1, 0, 1, 31, 1, 0);
    // idle cycles: outputs must hold
    cycle(0, 1, 0, 0, 7, 7, 0, 0, 7, 7, 0);
    cycle(0, 0, 1, 1, 1, 1, 0, 0, 1, 1, 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      cycle(($urandom % 8) != 0, int'($urandom % 4), 1'($urandom),
            1'($urandom), int'($urandom % 64) - 32, int'($urandom % 8),
            ($urandom % 10) == 0,
            1'($urandom), int'($urandom % 64) - 32, int'($urandom % 8),
            ($urandom % 10) == 0);
    end
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule